// File: doc/BRIEF.md
# Write-to-Set Command Status Register

This block holds the command bits that host software uses to hand work to a host controller, together with a small scheduling-overrun counter and its companion interrupt flag. Software reaches it over a simple single-cycle register bus. A write to the command register can only raise bits: each data bit written as 1 sets the matching command bit, and each bit written as 0 leaves its command bit as it was. Several commands can therefore be issued in separate accesses without one access undoing another. Hardware retires a command with a per-bit clear input once it has acted on it.

A second hardware input pulses once for each frame in which the periodic schedule did not finish before end of frame. Each pulse advances a 2-bit wrapping counter, which software can read in the command register, and raises a sticky flag in a separate interrupt status register. Software clears that flag by writing 1 to its bit.

The flag is held by a two-state machine. IRQ_IDLE moves to IRQ_PENDING on an overrun pulse (transition RAISE). IRQ_PENDING moves back to IRQ_IDLE on a write-1-to-clear with no overrun pulse in the same cycle (transition ACK). In all other cases each state holds (transition HOLD). Reset forces IRQ_IDLE.

Top module: `csr_cmd_status`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every command bit, the overrun counter and the overrun flag.
- R2: A write (`bus_sel` and `bus_wr` high) to offset 0 sets each command bit `cmd_q[i]` whose data bit `bus_wdata[i]` is 1, for i below NCMD. Command bits whose data bit is 0 keep their value. The new value is visible after that clock edge.
- R3: When `hw_clr[i]` is high at a clock edge and no write sets bit i in that cycle, `cmd_q[i]` is 0 after that edge.
- R4: If a software set and a hardware clear reach the same command bit in the same cycle, the bit ends up set.
- R5: `bus_rdata` follows `bus_addr` combinationally. Offset 0 returns the command bits in bits [NCMD-1:0] and the overrun counter in bits [17:16]. Offset 1 returns the overrun flag in bit 0. Every other bit, and every other offset, reads 0. Reading has no side effect.
- R6: Each clock edge with `sched_overrun` high adds 1 to `ovr_count`, wrapping from 3 to 0. With `sched_overrun` low the counter holds.
- R7: Writes to the counter field (bits [17:16] at offset 0) have no effect on the counter.
- R8: An edge with `sched_overrun` high sets `irq_overrun`. The flag then stays set until it is cleared as R9 describes.
- R9: A write to offset 1 with data bit 0 set clears `irq_overrun`, unless `sched_overrun` is high in the same cycle, in which case the flag stays set. A write with data bit 0 clear leaves the flag unchanged.
- R10: Bus cycles with `bus_sel` or `bus_wr` low change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe; a write happens when this and bus_sel are high |
| bus_addr | input | ADDR_W (2) | Register offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for the addressed register |
| hw_clr | input | NCMD (4) | Per-bit hardware clear of the command bits |
| sched_overrun | input | 1 | One-cycle pulse per frame whose periodic schedule overran |
| cmd_q | output | NCMD (4) | Current command bits |
| ovr_count | output | CNT_W (2) | Scheduling overrun counter |
| irq_overrun | output | 1 | Sticky scheduling-overrun interrupt flag |

## Verification
Every state change (command bits, counter, flag) is due one clock edge after the inputs that cause it: the bench applies stimulus just after a falling edge, lets one rising edge pass, and compares at the next falling edge. The read data has no register in its path, so it is compared in that same half cycle against the value the model holds after that edge. The reference model advances once per cycle in the bench, using the same inputs, and every output is compared on every clock. Directed cases cover same-cycle set against clear, the counter wrapping, and the overrun pulse arriving with an acknowledge. A random phase then mixes all inputs.

// File: rtl/csr_cmd_status_pkg.sv
package csr_cmd_status_pkg;
    // Register offsets on the bus.
    localparam int unsigned CMD_OFFSET = 0;
    localparam int unsigned IRQ_OFFSET = 1;
    // Bit of the overrun flag inside the interrupt status register.
    localparam int unsigned IRQ_OVR_BIT = 0;

    typedef enum logic [0:0] {
        IRQ_IDLE    = 1'b0,
        IRQ_PENDING = 1'b1
    } irq_state_t;
endpackage

// File: rtl/csr_cmd_bits.sv
module csr_cmd_bits #(
    parameter int unsigned NCMD = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCMD-1:0] set_vec,
    input  logic [NCMD-1:0] clr_vec,
    output logic [NCMD-1:0] cmd_q
);
    // One flop per command bit; a set outranks a clear in the same cycle.
    for (genvar i = 0; i < NCMD; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                cmd_q[i] <= 1'b0;
            else if (set_vec[i])
                cmd_q[i] <= 1'b1;
            else if (clr_vec[i])
                cmd_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/csr_ovr_counter.sv
module csr_ovr_counter #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    // Wraps naturally at 2**CNT_W.
    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (inc)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/csr_irq_fsm.sv
module csr_irq_fsm
    import csr_cmd_status_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic raise,
    input  logic ack,
    output logic flag
);
    irq_state_t state, state_nxt;

    always_ff @(posedge clk) begin
        if (rst)
            state <= IRQ_IDLE;
        else
            state <= state_nxt;
    end

    // RAISE, ACK and HOLD transitions; a raise outranks an ack.
    always_comb begin
        state_nxt = state;
        unique case (state)
            IRQ_IDLE:    if (raise) state_nxt = IRQ_PENDING;
            IRQ_PENDING: if (ack && !raise) state_nxt = IRQ_IDLE;
            default:     state_nxt = IRQ_IDLE;
        endcase
    end

    always_comb begin
        flag = (state == IRQ_PENDING);
    end
endmodule

// File: rtl/csr_cmd_status.sv
module csr_cmd_status
    import csr_cmd_status_pkg::*;
#(
    parameter int unsigned ADDR_W  = 2,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NCMD    = 4,
    parameter int unsigned CNT_W   = 2,
    parameter int unsigned CNT_LSB = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCMD-1:0]   hw_clr,
    input  logic              sched_overrun,
    output logic [NCMD-1:0]   cmd_q,
    output logic [CNT_W-1:0]  ovr_count,
    output logic              irq_overrun
);
    localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_OFFSET);
    localparam logic [ADDR_W-1:0] IRQ_A = ADDR_W'(IRQ_OFFSET);

    logic            wr_stb;
    logic            wr_cmd;
    logic            irq_ack;
    logic [NCMD-1:0] set_vec;

    assign wr_stb  = bus_sel && bus_wr;
    assign wr_cmd  = wr_stb && (bus_addr == CMD_A);
    assign set_vec = wr_cmd ? bus_wdata[NCMD-1:0] : '0;
    assign irq_ack = wr_stb && (bus_addr == IRQ_A) && bus_wdata[IRQ_OVR_BIT];

    // Only the command bits and the flag bit are consumed from the data.
    wire unused_wdata = ^bus_wdata;

    csr_cmd_bits #(.NCMD(NCMD)) u_bits (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (hw_clr),
        .cmd_q   (cmd_q)
    );

    csr_ovr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (sched_overrun),
        .count (ovr_count)
    );

    csr_irq_fsm u_irq (
        .clk   (clk),
        .rst   (rst),
        .raise (sched_overrun),
        .ack   (irq_ack),
        .flag  (irq_overrun)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CMD_A) begin
            bus_rdata[NCMD-1:0]                = cmd_q;
            bus_rdata[CNT_LSB +: CNT_W]        = ovr_count;
        end else if (bus_addr == IRQ_A) begin
            bus_rdata[IRQ_OVR_BIT]             = irq_overrun;
        end
    end
endmodule

// File: rtl/csr_cmd_status_chk.sv
module csr_cmd_status_chk #(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NCMD   = 4,
    parameter int unsigned CNT_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NCMD-1:0]   hw_clr,
    input logic              sched_overrun,
    input logic [NCMD-1:0]   cmd_q,
    input logic [CNT_W-1:0]  ovr_count,
    input logic              irq_overrun
);
    logic            rst_seen;
    logic [NCMD-1:0] sw_set;
    logic [NCMD-1:0] hw_only;
    logic            sw_ack;

    always_ff @(posedge clk) rst_seen <= rst;

    assign sw_set  = (bus_sel && bus_wr && bus_addr == ADDR_W'(0)) ? bus_wdata[NCMD-1:0] : '0;
    assign hw_only = hw_clr & ~sw_set;
    assign sw_ack  = bus_sel && bus_wr && bus_addr == ADDR_W'(1) && bus_wdata[0];

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst_seen |-> (cmd_q == '0 && ovr_count == '0 && !irq_overrun));

    assert_set_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (|sw_set) |=> ((cmd_q & $past(sw_set)) == $past(sw_set)));

    assert_hw_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (|hw_only) |=> ((cmd_q & $past(hw_only)) == '0));

    assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
        sched_overrun |=> (ovr_count == CNT_W'($past(ovr_count) + 1'b1)));

    assert_count_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !sched_overrun |=> $stable(ovr_count));

    assert_flag_raise_R8: assert property (@(posedge clk) disable iff (rst)
        sched_overrun |=> irq_overrun);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_overrun && !sw_ack) |=> irq_overrun);
endmodule

bind csr_cmd_status csr_cmd_status_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NCMD   (NCMD),
    .CNT_W  (CNT_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .hw_clr        (hw_clr),
    .sched_overrun (sched_overrun),
    .cmd_q         (cmd_q),
    .ovr_count     (ovr_count),
    .irq_overrun   (irq_overrun)
);

// File: tb/csr_cmd_status_test.sv
module csr_cmd_status_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  hw_clr = '0;
    logic        sched_overrun = 1'b0;
    logic [3:0]  cmd_q;
    logic [1:0]  ovr_count;
    logic        irq_overrun;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Behavioural reference state.
    int m_cmd = 0;
    int m_cnt = 0;
    int m_irq = 0;

    always #5 clk = ~clk;

    csr_cmd_status uut (
        .clk           (clk),
        .rst           (rst),
        .bus_sel       (bus_sel),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .hw_clr        (hw_clr),
        .sched_overrun (sched_overrun),
        .cmd_q         (cmd_q),
        .ovr_count     (ovr_count),
        .irq_overrun   (irq_overrun)
    );

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_rdata(int addr);
        if (addr == 0) return (m_cnt << 16) | m_cmd;
        if (addr == 1) return m_irq;
        return 0;
    endfunction

    // Drive one cycle, advance the model, compare after the edge.
    task automatic step(string tag, bit r, bit sel, bit wr, int addr, int wdata,
                        int clr, bit ovr);
        bit wr_stb;
        rst = r; bus_sel = sel; bus_wr = wr; bus_addr = 2'(addr);
        bus_wdata = wdata; hw_clr = 4'(clr); sched_overrun = ovr;
        wr_stb = sel && wr;
        if (r) begin
            m_cmd = 0; m_cnt = 0; m_irq = 0;
        end else begin
            m_cmd = (m_cmd & ~clr) & 'hF;
            if (wr_stb && addr == 0) m_cmd = m_cmd | (wdata & 'hF);
            if (ovr) m_irq = 1;
            else if (wr_stb && addr == 1 && (wdata & 1) != 0) m_irq = 0;
            if (ovr) m_cnt = (m_cnt + 1) % 4;
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, "cmd_q", int'(cmd_q), m_cmd);
        check(tag, "ovr_count", int'(ovr_count), m_cnt);
        check(tag, "irq_overrun", int'(irq_overrun), m_irq);
        check(tag, "bus_rdata", int'(bus_rdata), exp_rdata(addr));
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        step("R1", 1, 0, 0, 0, 0, 0, 0);
        step("R1", 1, 1, 1, 0, 'hF, 0, 1);
        // R2: set-only writes accumulate
        step("R2", 0, 1, 1, 0, 'h5, 0, 0);
        step("R2", 0, 1, 1, 0, 'h2, 0, 0);
        step("R2", 0, 1, 1, 0, 'h0, 0, 0);
        // R3: hardware clear of a single bit
        step("R3", 0, 0, 0, 0, 0, 'h1, 0);
        step("R3", 0, 0, 0, 0, 0, 'h6, 0);
        // R4: set and clear on the same bit, set wins
        step("R4", 0, 1, 1, 0, 'h8, 'h8, 0);
        step("R4", 0, 1, 1, 0, 'h1, 'h9, 0);
        // R10: no write without both strobes
        step("R10", 0, 1, 0, 0, 'hF, 0, 0);
        step("R10", 0, 0, 1, 0, 'hF, 0, 0);
        step("R10", 0, 0, 1, 1, 'h1, 0, 1);
        // R7: counter field ignores writes
        step("R7", 0, 1, 1, 0, 'h30000, 0, 0);
        // R6 / R8: overrun pulses, wrap 3 -> 0
        for (int k = 0; k < 4; k++) step("R6", 0, 0, 0, 0, 0, 0, 1);
        step("R8", 0, 0, 0, 1, 0, 0, 0);
        // R9: ack with bit 0 clear has no effect
        step("R9", 0, 1, 1, 1, 'hFFFE, 0, 0);
        // R9: overrun with ack keeps the flag
        step("R9", 0, 1, 1, 1, 'h1, 0, 1);
        // R9: plain ack clears the flag
        step("R9", 0, 1, 1, 1, 'h1, 0, 0);
        // R5: unmapped offsets read zero
        step("R5", 0, 0, 0, 2, 0, 0, 0);
        step("R5", 0, 0, 0, 3, 0, 0, 0);
        // R1: mid-run reset
        step("R1", 1, 0, 0, 0, 0, 0, 0);
        // Random mix
        for (int k = 0; k < 400; k++) begin
            step("R2", 0, 1'($urandom), 1'($urandom), int'($urandom % 4),
                 int'($urandom), int'($urandom % 16), ($urandom % 4) == 0);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule